// File: doc/BRIEF.md
# Embedded-Clock Receiver Sequencer

This block is the top-level control state machine for a receiver on a serial link that carries its clock inside the data. Each packet on the link has N data bits and two extra bits that hold the clock edge. A start request begins a training phase. During training the incoming pattern is routed straight through as the delay-loop reference, and a replica path is switched on. This gives the bypassed clock the same delay as an extracted clock will have later.

Training has a fixed minimum length. After it, the sequencer waits for the delay loop to report lock. Then the replica path and the bypass are switched off, and the block moves to extraction: it recovers one embedded clock per packet. Each extraction that succeeds gives one recovered packet, marked by a single-cycle data-valid pulse, and then the block prepares for the next packet.

The policy is fail-stop. A failed extraction stops sampling-clock generation and halts the receiver. A programmable silence timeout does the same. The receiver stays halted until a reset or a new start request.

Top module: `ecr_seq`

## Requirements
- R1: While reset is held, and after it until start_i is seen, all five outputs are low. lock_i, ext_ok_i and ext_fail_i have no effect in this state.
- R2: start_i high at a rising edge in the idle state raises train_bypass_o and replica_en_o from the next cycle. The training phase lasts exactly TRAIN_CYCLES cycles.
- R3: lock_i is ignored during training. After training, bypass and replica stay high, one waiting cycle at least, until lock_i is high at an edge. In the next cycle both are low and samp_clk_en_o is high.
- R4: ext_ok_i high at an edge during extraction makes data_valid_o high for exactly one cycle, while samp_clk_en_o stays high. The following cycle is extraction again.
- R5: ext_fail_i high at an edge during extraction makes halted_o high and samp_clk_en_o low in the next cycle. ext_fail_i wins over a simultaneous ext_ok_i.
- R6: If neither strobe is seen for timeout_cycles_i consecutive extraction cycles, the block halts in the following cycle. The count restarts on every entry to extraction. A value of 0 disables the timeout.
- R7: halted_o stays high, and strobes and lock_i are ignored, until reset returns the block to idle or start_i re-enters training in the next cycle.
- R8: Strobes that arrive in the cycle where data_valid_o is high are ignored. The next cycle is always extraction.
- R9: start_i is ignored outside the idle and halted states. It neither restarts nor lengthens training.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin (or restart) training |
| lock_i | input | 1 | Delay loop reports lock |
| ext_ok_i | input | 1 | Embedded clock of current packet extracted |
| ext_fail_i | input | 1 | Extraction of current packet failed |
| timeout_cycles_i | input | TO_W | Extraction silence limit in cycles, 0 = off |
| train_bypass_o | output | 1 | Route training pattern straight to the delay loop |
| replica_en_o | output | 1 | Enable delay-matching replica path |
| samp_clk_en_o | output | 1 | Sampling-clock generation enabled |
| data_valid_o | output | 1 | One pulse per recovered packet |
| halted_o | output | 1 | Receiver stopped after a failure |

## Verification
All outputs are decoded from the state register. Each strobe therefore shows up in the cycle after the rising edge that samples it: one edge for lock, ok, fail and start. Training shows TRAIN_CYCLES training cycles plus one waiting cycle before lock can act. A silence limit of T gives exactly T extraction cycles before the halt is visible. The bench changes inputs only on falling edges and reads outputs on the falling edge after the next rising edge. Every expected value is tied to a fixed edge count, with no polling.

// File: rtl/ecr_seq_pkg.sv
package ecr_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE      = 3'd0,
    ST_TRAIN     = 3'd1,
    ST_WAIT_LOCK = 3'd2,
    ST_EXTRACT   = 3'd3,
    ST_RECOVER   = 3'd4,
    ST_HALT      = 3'd5
  } ecr_state_e;
endpackage

// File: rtl/ecr_seq_timer.sv
module ecr_seq_timer #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         run_i,
  input  logic [W-1:0] limit_i,
  output logic         expire_o
);
  logic [W-1:0] cnt_q;

  // counts cycles while run_i; limit 0 never expires
  assign expire_o = run_i && (limit_i != '0) && (cnt_q == limit_i - W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cnt_q <= '0;
    else if (!run_i)   cnt_q <= '0;
    else if (expire_o) cnt_q <= '0;
    else               cnt_q <= cnt_q + W'(1);
  end
endmodule

// File: rtl/ecr_seq_ctrl.sv
module ecr_seq_ctrl
  import ecr_seq_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic       lock_i,
  input  logic       ext_ok_i,
  input  logic       ext_fail_i,
  input  logic       train_done_i,
  input  logic       ext_tmo_i,
  output ecr_state_e state_o
);
  ecr_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:      if (start_i) state_d = ST_TRAIN;
      ST_TRAIN:     if (train_done_i) state_d = ST_WAIT_LOCK;
      ST_WAIT_LOCK: if (lock_i) state_d = ST_EXTRACT;
      ST_EXTRACT: begin
        // priority: fail, then success, then silence timeout
        if (ext_fail_i)    state_d = ST_HALT;
        else if (ext_ok_i) state_d = ST_RECOVER;
        else if (ext_tmo_i) state_d = ST_HALT;
      end
      ST_RECOVER:   state_d = ST_EXTRACT;
      ST_HALT:      if (start_i) state_d = ST_TRAIN;
      default:      state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign state_o = state_q;
endmodule

// File: rtl/ecr_seq_outdec.sv
module ecr_seq_outdec
  import ecr_seq_pkg::*;
(
  input  ecr_state_e state_i,
  output logic       train_bypass_o,
  output logic       replica_en_o,
  output logic       samp_clk_en_o,
  output logic       data_valid_o,
  output logic       halted_o,
  output logic       in_train_o,
  output logic       in_extract_o
);
  always_comb begin
    train_bypass_o = 1'b0;
    replica_en_o   = 1'b0;
    samp_clk_en_o  = 1'b0;
    data_valid_o   = 1'b0;
    halted_o       = 1'b0;
    unique case (state_i)
      ST_TRAIN, ST_WAIT_LOCK: begin
        train_bypass_o = 1'b1;
        replica_en_o   = 1'b1;
      end
      ST_EXTRACT: samp_clk_en_o = 1'b1;
      ST_RECOVER: begin
        samp_clk_en_o = 1'b1;
        data_valid_o  = 1'b1;
      end
      ST_HALT:    halted_o = 1'b1;
      default: ;
    endcase
  end

  assign in_train_o   = (state_i == ST_TRAIN);
  assign in_extract_o = (state_i == ST_EXTRACT);
endmodule

// File: rtl/ecr_seq.sv
module ecr_seq
  import ecr_seq_pkg::*;
#(
  parameter int TRAIN_CYCLES = 16,
  parameter int TO_W         = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic            lock_i,
  input  logic            ext_ok_i,
  input  logic            ext_fail_i,
  input  logic [TO_W-1:0] timeout_cycles_i,
  output logic            train_bypass_o,
  output logic            replica_en_o,
  output logic            samp_clk_en_o,
  output logic            data_valid_o,
  output logic            halted_o
);
  localparam int TRN_W = $clog2(TRAIN_CYCLES + 1);

  ecr_state_e state;
  logic       in_train, in_extract, train_done, ext_tmo;

  ecr_seq_ctrl u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (start_i),
    .lock_i       (lock_i),
    .ext_ok_i     (ext_ok_i),
    .ext_fail_i   (ext_fail_i),
    .train_done_i (train_done),
    .ext_tmo_i    (ext_tmo),
    .state_o      (state)
  );

  ecr_seq_timer #(.W(TRN_W)) u_train_tmr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_i    (in_train),
    .limit_i  (TRN_W'(TRAIN_CYCLES)),
    .expire_o (train_done)
  );

  ecr_seq_timer #(.W(TO_W)) u_ext_tmr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_i    (in_extract),
    .limit_i  (timeout_cycles_i),
    .expire_o (ext_tmo)
  );

  ecr_seq_outdec u_dec (
    .state_i        (state),
    .train_bypass_o (train_bypass_o),
    .replica_en_o   (replica_en_o),
    .samp_clk_en_o  (samp_clk_en_o),
    .data_valid_o   (data_valid_o),
    .halted_o       (halted_o),
    .in_train_o     (in_train),
    .in_extract_o   (in_extract)
  );
endmodule

// File: rtl/ecr_seq_chk.sv
module ecr_seq_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic start_i,
  input logic lock_i,
  input logic ext_fail_i,
  input logic train_bypass_o,
  input logic samp_clk_en_o,
  input logic data_valid_o,
  input logic halted_o
);
  // R4
  a_r4_single_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_valid_o |=> !data_valid_o);

  // R5
  a_r5_fail_halts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (samp_clk_en_o && !data_valid_o && ext_fail_i) |=> halted_o);

  // R5
  a_r5_halt_from_extract: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(halted_o) |-> $past(samp_clk_en_o && !data_valid_o));

  // R7
  a_r7_halt_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (halted_o && !start_i) |=> halted_o);

  // R3
  a_r3_lock_exit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(train_bypass_o) |-> ($past(lock_i) && samp_clk_en_o));

  // R2
  a_r2_phase_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({train_bypass_o, samp_clk_en_o, halted_o}));
endmodule

bind ecr_seq ecr_seq_chk u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .start_i        (start_i),
  .lock_i         (lock_i),
  .ext_fail_i     (ext_fail_i),
  .train_bypass_o (train_bypass_o),
  .samp_clk_en_o  (samp_clk_en_o),
  .data_valid_o   (data_valid_o),
  .halted_o       (halted_o)
);

// File: tb/ecr_seq_test.sv
module ecr_seq_test;
  localparam int CLK_PERIOD = 10;
  localparam int TRN        = 4;
  localparam int TOW        = 8;

  // output vector {bypass, replica, samp_en, valid, halted}
  localparam logic [4:0] O_IDLE = 5'b00000;
  localparam logic [4:0] O_TRN  = 5'b11000;
  localparam logic [4:0] O_EXT  = 5'b00100;
  localparam logic [4:0] O_REC  = 5'b00110;
  localparam logic [4:0] O_HLT  = 5'b00001;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic start = 1'b0, lock = 1'b0, ok = 1'b0, fail = 1'b0;
  logic [TOW-1:0] tmo = '0;
  logic byp, rep, sen, dv, hlt;
  logic [4:0] outv;
  int checks = 0;
  int errors = 0;
  int cyc = 0;

  assign outv = {byp, rep, sen, dv, hlt};

  always #(CLK_PERIOD/2) clk = ~clk;

  ecr_seq #(.TRAIN_CYCLES(TRN), .TO_W(TOW)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start), .lock_i(lock),
    .ext_ok_i(ok), .ext_fail_i(fail), .timeout_cycles_i(tmo),
    .train_bypass_o(byp), .replica_en_o(rep), .samp_clk_en_o(sen),
    .data_valid_o(dv), .halted_o(hlt)
  );

  task automatic chk(input string req, input logic [4:0] exp);
    checks++;
    if (outv !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b", req, outv, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  // start, run training, wait n extra cycles without lock, then lock
  task automatic to_extract(input int wait_n);
    start = 1'b1; step(); start = 1'b0;
    chk("R2 train entry", O_TRN);
    for (int i = 1; i < TRN; i++) begin step(); chk("R2 training", O_TRN); end
    step(); chk("R3 wait lock", O_TRN);
    for (int i = 0; i < wait_n; i++) begin step(); chk("R3 no lock hold", O_TRN); end
    lock = 1'b1; step(); lock = 1'b0;
    chk("R3 lock to extract", O_EXT);
  endtask

  task automatic t_reset();
    #1 chk("R1 during reset", O_IDLE);
    @(negedge clk); rst_ni = 1'b1;
    lock = 1'b1; ok = 1'b1; fail = 1'b1;
    for (int i = 0; i < 3; i++) begin step(); chk("R1 idle ignores strobes", O_IDLE); end
    lock = 1'b0; ok = 1'b0; fail = 1'b0;
  endtask

  task automatic t_train_lock_ignored();
    // lock and start held high through training: both must be ignored
    start = 1'b1; step();
    lock = 1'b1;
    chk("R2 train entry", O_TRN);
    for (int i = 1; i < TRN; i++) begin step(); chk("R3 R9 training fixed length", O_TRN); end
    start = 1'b0;
    step(); chk("R3 wait-lock cycle after training", O_TRN);
    step(); lock = 1'b0;
    chk("R3 lock accepted", O_EXT);
  endtask

  task automatic t_recover();
    for (int i = 0; i < 20; i++) begin step(); chk("R6 zero disables timeout", O_EXT); end
    ok = 1'b1; step();
    chk("R4 valid pulse", O_REC);
    fail = 1'b1;
    step(); ok = 1'b0; fail = 1'b0;
    chk("R8 strobes ignored in recover", O_EXT);
    step(); chk("R4 stays extracting", O_EXT);
    ok = 1'b1;
    step(); chk("R4 back-to-back 1", O_REC);
    step(); chk("R4 back-to-back 2", O_EXT);
    step(); chk("R4 back-to-back 3", O_REC);
    ok = 1'b0;
    step(); chk("R4 back-to-back 4", O_EXT);
  endtask

  task automatic t_fail_priority();
    ok = 1'b1; fail = 1'b1; step(); ok = 1'b0; fail = 1'b0;
    chk("R5 fail wins over ok", O_HLT);
    for (int i = 0; i < 5; i++) begin
      lock = i[0]; ok = ~i[0]; fail = 1'b1;
      step(); chk("R7 halt sticky", O_HLT);
    end
    lock = 1'b0; ok = 1'b0; fail = 1'b0;
  endtask

  task automatic t_restart_from_halt();
    start = 1'b1; step(); start = 1'b0;
    chk("R7 start leaves halt", O_TRN);
    for (int i = 1; i < TRN; i++) begin step(); chk("R2 retrain", O_TRN); end
    step(); chk("R3 wait lock", O_TRN);
    start = 1'b1;
    step(); start = 1'b0;
    chk("R9 start ignored in wait-lock", O_TRN);
    lock = 1'b1; step(); lock = 1'b0;
    chk("R3 lock", O_EXT);
  endtask

  task automatic t_timeout();
    tmo = 8'd3;
    step(); chk("R6 silence 2", O_EXT);
    ok = 1'b1; step(); ok = 1'b0;
    chk("R4 ok before timeout", O_REC);
    step(); chk("R6 count restarted 1", O_EXT);
    step(); chk("R6 count restarted 2", O_EXT);
    step(); chk("R6 count restarted 3", O_EXT);
    step(); chk("R6 timeout halts", O_HLT);
  endtask

  task automatic t_reset_in_halt();
    rst_ni = 1'b0;
    #1 chk("R7 reset leaves halt", O_IDLE);
    @(negedge clk); rst_ni = 1'b1;
    step(); chk("R1 idle after reset", O_IDLE);
  endtask

  task automatic t_fail_plain();
    tmo = '0;
    to_extract(3);
    fail = 1'b1; step(); fail = 1'b0;
    chk("R5 fail halts", O_HLT);
  endtask

  initial begin
    t_reset();
    t_train_lock_ignored();
    t_recover();
    t_fail_priority();
    t_restart_from_halt();
    t_timeout();
    t_reset_in_halt();
    t_fail_plain();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got %0d cycles expected under 20000", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule